// File: doc/BRIEF.md
# Debug Break Condition Comparator

A hardware breakpoint unit with a configurable number of channels (two by default) that watches the bus cycles of a processor. When a cycle meets the condition programmed into a channel, the unit raises a break interrupt request. Each channel holds a compare address and a set of cycle qualifiers. The qualifiers select the bus master, the cycle kind (instruction fetch or data access), the direction and the operand size. A further bit picks whether an instruction break is taken before or after the instruction executes. The last channel also holds a data value with a bit mask that is compared on data cycles.

A fetch always moves one 32-bit word holding two 16-bit instructions. A matching fetch only arms the channel, for the instruction half picked by address bit 1. The break itself is tied to the execute-confirmation stream from the core. Instructions that were fetched and then discarded therefore never break. When the target instruction cannot take an interrupt (a delay slot, or after an instruction that blocks interrupts), the request waits for the first later instruction that can take one.

Data-cycle address matching ignores the low address bits that the access size covers. A channel programmed with an unaligned byte address therefore also catches the word and longword accesses that contain that byte. Each channel keeps a sticky match flag, and the request output is the OR of the flags of the enabled channels.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset all match flags are 0 and `brk_req` is 0; `brk_req` is never 1 while every flag is 0.
- R2: A fetch cycle arms a channel when address bits [31:2] equal the channel address. Only the instruction whose address bits [31:1] equal the channel address can then break; executing the other half of the same word does not.
- R3: With `brk_post`=0, the flag is set at the clock edge where the armed instruction is presented on `exec_valid` with `exec_intok`=1, and `brk_req` is 1 from the following cycle.
- R4: With `brk_post`=1, executing the armed instruction sets no flag; the flag is set at the next later `exec_valid` that has `exec_intok`=1.
- R5: A fetched instruction that never appears on `exec_valid` (overrun fetch) never sets a flag.
- R6: A pending break is held while `exec_valid` comes with `exec_intok`=0 and is delivered at the first `exec_valid` with `exec_intok`=1, in both timing modes.
- R7: On data cycles the address is compared after masking by the bus size (`bus_size` 0 = byte, all bits; 1 = word, bit 0 ignored; 2 = longword, bits 1:0 ignored). Channel address 0x1003 matches longword 0x1000, word 0x1002 and byte 0x1003, but not byte 0x1002 or word 0x1000.
- R8: Size condition `brk_size`: 00 = any; 01, 10 and 11 require a byte, word or longword bus size respectively.
- R9: Qualifier fields are two-bit allow masks, and 11 means any. `brk_master` bit 0 allows the CPU and bit 1 other masters. `brk_kind` bit 0 allows fetch and bit 1 data. `brk_dir` bit 0 allows read and bit 1 write.
- R10: On the last channel a data cycle matches only if `(bus_data ^ brk_dval) & brk_dmask` is 0; fetch breaks on that channel ignore the data.
- R11: A bus cycle with `bus_dummy`=1 never matches.
- R12: Flags are sticky until `brk_clr` for that channel is 1; a match in the same cycle as the clear wins.
- R13: A channel with `brk_en`=0 neither sets its flag nor contributes to `brk_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_addr | input | NUM_CH x ADDR_W | Compare address per channel |
| brk_master | input | NUM_CH x 2 | Master allow mask per channel |
| brk_kind | input | NUM_CH x 2 | Fetch/data allow mask per channel |
| brk_dir | input | NUM_CH x 2 | Read/write allow mask per channel |
| brk_size | input | NUM_CH x 2 | Size condition per channel |
| brk_post | input | NUM_CH | 1 = break after execution |
| brk_en | input | NUM_CH | Channel enable |
| brk_clr | input | NUM_CH | Clear the channel's match flag |
| brk_dval | input | DATA_W | Data compare value, last channel |
| brk_dmask | input | DATA_W | Data compare bit mask, last channel |
| bus_valid | input | 1 | A bus cycle is observed |
| bus_cpu | input | 1 | Cycle driven by the CPU |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | Cycle is a write |
| bus_dummy | input | 1 | Dummy cycle, never matched |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_addr | input | ADDR_W | Cycle address |
| bus_data | input | DATA_W | Cycle data |
| exec_valid | input | 1 | An instruction is confirmed to execute |
| exec_pc | input | ADDR_W | Address of that instruction |
| exec_intok | input | 1 | An interrupt may be taken before it |
| brk_flag | output | NUM_CH | Sticky match flags |
| brk_req | output | 1 | Break interrupt request |

## Verification
A corrupted arm or pending bit shows up as a flag that rises on the wrong instruction. It may rise at the other half of a fetched word, on an overrun fetch, or one instruction too early or too late relative to `exec_intok`. The error is visible on `brk_flag` one clock after that `exec_valid`. A wrong address mask or qualifier decode shows on the cycle after the offending data access, as a flag that is set when it should stay clear or clear when it should be set. Because flags are sticky, a spurious set then persists until the next clear and cannot be hidden by later cycles.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

  // bus size codes as seen on the observation interface
  localparam logic [1:0] BSZ_BYTE = 2'd0;
  localparam logic [1:0] BSZ_WORD = 2'd1;
  localparam logic [1:0] BSZ_LONG = 2'd2;

  // size condition codes in a channel
  localparam logic [1:0] SZC_ANY = 2'd0;

  typedef struct packed {
    logic [1:0] master;  // bit0 cpu, bit1 other master
    logic [1:0] kind;    // bit0 fetch, bit1 data
    logic [1:0] dir;     // bit0 read, bit1 write
    logic [1:0] size;    // 0 any, 1 byte, 2 word, 3 long
  } brk_qual_t;

  function automatic logic size_ok(input logic [1:0] cond, input logic [1:0] bsz);
    return (cond == SZC_ANY) || (cond == bsz + 2'd1);
  endfunction

endpackage

// File: rtl/brk_cycle_match.sv
module brk_cycle_match
  import dbg_brk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [ADDR_W-1:0] cfg_addr,
  input  brk_qual_t         cfg_qual,
  input  logic [DATA_W-1:0] cfg_dval,
  input  logic [DATA_W-1:0] cfg_dmask,
  input  logic              bus_valid,
  input  logic              bus_cpu,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic              bus_dummy,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              fetch_hit,
  output logic              data_hit
);

  localparam int LW_LSB = 2;

  logic [ADDR_W-1:0] amask;
  logic              master_ok, dir_ok, common_ok;
  logic              fetch_addr_eq, data_addr_eq, data_ok;

  always_comb begin
    amask = '1;
    case (bus_size)
      BSZ_WORD: amask[0]   = 1'b0;
      BSZ_LONG: amask[1:0] = 2'b00;
      default:  amask      = '1;
    endcase
  end

  assign master_ok     = bus_cpu   ? cfg_qual.master[0] : cfg_qual.master[1];
  assign dir_ok        = bus_write ? cfg_qual.dir[1]    : cfg_qual.dir[0];
  assign common_ok     = bus_valid && !bus_dummy && master_ok && dir_ok &&
                         size_ok(cfg_qual.size, bus_size);
  assign fetch_addr_eq = (bus_addr[ADDR_W-1:LW_LSB] == cfg_addr[ADDR_W-1:LW_LSB]);
  assign data_addr_eq  = (((bus_addr ^ cfg_addr) & amask) == '0);

  generate
    if (HAS_DATA) begin : g_dcmp
      assign data_ok = (((bus_data ^ cfg_dval) & cfg_dmask) == '0);
    end else begin : g_nodcmp
      assign data_ok = 1'b1;
    end
  endgenerate

  assign fetch_hit = common_ok &&  bus_fetch && cfg_qual.kind[0] && fetch_addr_eq;
  assign data_hit  = common_ok && !bus_fetch && cfg_qual.kind[1] && data_addr_eq && data_ok;

endmodule

// File: rtl/brk_exec_track.sv
module brk_exec_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              post,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              fetch_hit,
  input  logic              exec_valid,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic              exec_intok,
  output logic              exec_fire
);

  logic armed_q, armed_d;
  logic pend_q, pend_d;
  logic upd;
  logic pc_hit, fire_now, fire_pend, new_pend;

  assign pc_hit    = exec_valid && armed_q &&
                     (exec_pc[ADDR_W-1:1] == cfg_addr[ADDR_W-1:1]);
  assign fire_now  = pc_hit && !post && exec_intok;
  assign fire_pend = pend_q && exec_valid && exec_intok;
  assign new_pend  = pc_hit && (post || !exec_intok);
  assign exec_fire = en && (fire_now || fire_pend);
  assign upd       = fetch_hit || exec_valid || !en;

  always_comb begin
    armed_d = armed_q;
    pend_d  = (pend_q && !fire_pend) || new_pend;
    if (fetch_hit)   armed_d = 1'b1;
    else if (pc_hit) armed_d = 1'b0;
    if (!en) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (upd) begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import dbg_brk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  brk_qual_t         cfg_qual,
  input  logic              cfg_post,
  input  logic              cfg_en,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] cfg_dval,
  input  logic [DATA_W-1:0] cfg_dmask,
  input  logic              bus_valid,
  input  logic              bus_cpu,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic              bus_dummy,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              exec_valid,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic              exec_intok,
  output logic              flag
);

  logic fetch_hit, data_hit, exec_fire;
  logic flag_q, flag_d, flag_upd;

  brk_cycle_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(HAS_DATA)
  ) i_match (
    .cfg_addr (cfg_addr),
    .cfg_qual (cfg_qual),
    .cfg_dval (cfg_dval),
    .cfg_dmask(cfg_dmask),
    .bus_valid(bus_valid),
    .bus_cpu  (bus_cpu),
    .bus_fetch(bus_fetch),
    .bus_write(bus_write),
    .bus_dummy(bus_dummy),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .fetch_hit(fetch_hit),
    .data_hit (data_hit)
  );

  brk_exec_track #(.ADDR_W(ADDR_W)) i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .post      (cfg_post),
    .cfg_addr  (cfg_addr),
    .fetch_hit (fetch_hit && cfg_en),
    .exec_valid(exec_valid),
    .exec_pc   (exec_pc),
    .exec_intok(exec_intok),
    .exec_fire (exec_fire)
  );

  assign flag_upd = flag_clr || exec_fire || (cfg_en && data_hit);

  always_comb begin
    flag_d = flag_q && !flag_clr;
    if (exec_fire || (cfg_en && data_hit)) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_upd) flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
  import dbg_brk_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  brk_addr,
  input  logic [NUM_CH-1:0][1:0]         brk_master,
  input  logic [NUM_CH-1:0][1:0]         brk_kind,
  input  logic [NUM_CH-1:0][1:0]         brk_dir,
  input  logic [NUM_CH-1:0][1:0]         brk_size,
  input  logic [NUM_CH-1:0]              brk_post,
  input  logic [NUM_CH-1:0]              brk_en,
  input  logic [NUM_CH-1:0]              brk_clr,
  input  logic [DATA_W-1:0]              brk_dval,
  input  logic [DATA_W-1:0]              brk_dmask,
  input  logic                           bus_valid,
  input  logic                           bus_cpu,
  input  logic                           bus_fetch,
  input  logic                           bus_write,
  input  logic                           bus_dummy,
  input  logic [1:0]                     bus_size,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_data,
  input  logic                           exec_valid,
  input  logic [ADDR_W-1:0]              exec_pc,
  input  logic                           exec_intok,
  output logic [NUM_CH-1:0]              brk_flag,
  output logic                           brk_req
);

  localparam int DATA_CH = NUM_CH - 1;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      brk_qual_t qual;
      assign qual = '{master: brk_master[ch], kind: brk_kind[ch],
                      dir: brk_dir[ch], size: brk_size[ch]};

      brk_channel #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(ch == DATA_CH)
      ) i_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (brk_addr[ch]),
        .cfg_qual  (qual),
        .cfg_post  (brk_post[ch]),
        .cfg_en    (brk_en[ch]),
        .flag_clr  (brk_clr[ch]),
        .cfg_dval  (brk_dval),
        .cfg_dmask (brk_dmask),
        .bus_valid (bus_valid),
        .bus_cpu   (bus_cpu),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .bus_dummy (bus_dummy),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .exec_valid(exec_valid),
        .exec_pc   (exec_pc),
        .exec_intok(exec_intok),
        .flag      (brk_flag[ch])
      );
    end
  endgenerate

  assign brk_req = |(brk_flag & brk_en);

endmodule

// File: rtl/dbg_break_chk.sv
module dbg_break_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] brk_en,
  input logic [NUM_CH-1:0] brk_clr,
  input logic              bus_valid,
  input logic              bus_dummy,
  input logic              exec_valid,
  input logic              exec_intok,
  input logic [NUM_CH-1:0] brk_flag,
  input logic              brk_req
);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag == '0) |-> !brk_req);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr[i] && !bus_valid && !exec_valid) |=> !brk_flag[i]);

      assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag[i] && !brk_clr[i]) |=> brk_flag[i]);

      assert_dummy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_dummy && !exec_valid && !brk_flag[i]) |=> !brk_flag[i]);

      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_intok && !bus_valid && !brk_flag[i]) |=> !brk_flag[i]);

      assert_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_en[i] && !brk_flag[i]) |=> !brk_flag[i]);
    end
  endgenerate

endmodule

bind dbg_break_unit dbg_break_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .brk_en    (brk_en),
  .brk_clr   (brk_clr),
  .bus_valid (bus_valid),
  .bus_dummy (bus_dummy),
  .exec_valid(exec_valid),
  .exec_intok(exec_intok),
  .brk_flag  (brk_flag),
  .brk_req   (brk_req)
);

// File: tb/test_dbg_break_unit.sv
`timescale 1ns/1ps
module test_dbg_break_unit;

  localparam int NCH = 2;

  logic                 clk, rst_n;
  logic [NCH-1:0][31:0] brk_addr;
  logic [NCH-1:0][1:0]  brk_master, brk_kind, brk_dir, brk_size;
  logic [NCH-1:0]       brk_post, brk_en, brk_clr;
  logic [31:0]          brk_dval, brk_dmask;
  logic                 bus_valid, bus_cpu, bus_fetch, bus_write, bus_dummy;
  logic [1:0]           bus_size;
  logic [31:0]          bus_addr, bus_data;
  logic                 exec_valid, exec_intok;
  logic [31:0]          exec_pc;
  logic [NCH-1:0]       brk_flag;
  logic                 brk_req;

  typedef struct {
    string          tag;
    logic [NCH-1:0] f;
    logic           r;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  dbg_break_unit #(.NUM_CH(NCH)) i_dbg_break_unit (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: compare one expected item per clock
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (brk_flag !== e.f || brk_req !== e.r) begin
        n_bad++;
        $display("FAIL %s: flags=%b req=%b expected flags=%b req=%b",
                 e.tag, brk_flag, brk_req, e.f, e.r);
      end
    end
  end

  task automatic cyc(input string tag, input logic [NCH-1:0] ef, input logic er);
    q.push_back('{tag: tag, f: ef, r: er});
    @(negedge clk);
    bus_valid = 1'b0; exec_valid = 1'b0; brk_clr = '0; bus_dummy = 1'b0;
  endtask

  task automatic setch(input int i, input logic [31:0] a, input logic [1:0] m,
                       input logic [1:0] k, input logic [1:0] d, input logic [1:0] s,
                       input logic p, input logic e);
    brk_addr[i] = a; brk_master[i] = m; brk_kind[i] = k;
    brk_dir[i] = d; brk_size[i] = s; brk_post[i] = p; brk_en[i] = e;
  endtask

  task automatic bus(input logic f, input logic w, input logic c, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] dat, input logic dum);
    bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_cpu = c;
    bus_size = sz; bus_addr = a; bus_data = dat; bus_dummy = dum;
  endtask

  task automatic exe(input logic [31:0] pc, input logic ok);
    exec_valid = 1'b1; exec_pc = pc; exec_intok = ok;
  endtask

  task automatic fetch(input logic [31:0] a);
    bus(1'b1, 1'b0, 1'b1, 2'd2, a, 32'h0, 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    brk_addr = '0; brk_master = '0; brk_kind = '0; brk_dir = '0; brk_size = '0;
    brk_post = '0; brk_en = '0; brk_clr = '0; brk_dval = '0; brk_dmask = '0;
    bus_valid = 0; bus_cpu = 1; bus_fetch = 0; bus_write = 0; bus_dummy = 0;
    bus_size = 0; bus_addr = '0; bus_data = '0;
    exec_valid = 0; exec_pc = '0; exec_intok = 1;
    @(negedge clk);
    cyc("R1 reset", 2'b00, 0);
    cyc("R1 reset", 2'b00, 0);
    rst_n = 1'b1;
    cyc("R1 after release", 2'b00, 0);

    // R2/R3 pre-execution fetch break on the upper half
    setch(0, 32'h2002, 2'b11, 2'b01, 2'b11, 2'b00, 1'b0, 1'b1);
    fetch(32'h2000);       cyc("R2 fetch arms only", 2'b00, 0);
    exe(32'h2000, 1'b1);   cyc("R2 other half no break", 2'b00, 0);
    exe(32'h2002, 1'b1);   cyc("R3 pre break", 2'b01, 1);
    brk_clr = 2'b01;       cyc("R12 clear", 2'b00, 0);

    // R4 post-execution
    brk_post[0] = 1'b1;
    fetch(32'h2000);       cyc("R4 fetch", 2'b00, 0);
    exe(32'h2002, 1'b1);   cyc("R4 not at target", 2'b00, 0);
    exe(32'h2004, 1'b1);   cyc("R4 at next instr", 2'b01, 1);
    brk_clr = 2'b01;       cyc("R12 clear", 2'b00, 0);

    // R5 overrun fetch
    brk_post[0] = 1'b0;
    fetch(32'h2000);       cyc("R5 fetch", 2'b00, 0);
    exe(32'h2010, 1'b1);   cyc("R5 branch target", 2'b00, 0);
    cyc("R5 idle", 2'b00, 0);

    // R6 deferral, pre
    fetch(32'h2000);       cyc("R6 fetch", 2'b00, 0);
    exe(32'h2002, 1'b0);   cyc("R6 pre held", 2'b00, 0);
    exe(32'h2004, 1'b0);   cyc("R6 pre still held", 2'b00, 0);
    exe(32'h2006, 1'b1);   cyc("R6 pre delivered", 2'b01, 1);
    brk_clr = 2'b01;       cyc("R12 clear", 2'b00, 0);

    // R6 deferral, post
    brk_post[0] = 1'b1;
    fetch(32'h2000);       cyc("R6 fetch", 2'b00, 0);
    exe(32'h2002, 1'b1);   cyc("R6 post target", 2'b00, 0);
    exe(32'h2004, 1'b0);   cyc("R6 post held", 2'b00, 0);
    exe(32'h2006, 1'b1);   cyc("R6 post delivered", 2'b01, 1);
    brk_clr = 2'b01;       cyc("R12 clear", 2'b00, 0);

    // R7 size-masked data address
    setch(0, 32'h1003, 2'b11, 2'b10, 2'b11, 2'b00, 1'b0, 1'b1);
    bus(0, 0, 1, 2'd2, 32'h1000, 0, 0); cyc("R7 long 1000", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);
    bus(0, 0, 1, 2'd1, 32'h1002, 0, 0); cyc("R7 word 1002", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); cyc("R7 byte 1003", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);
    bus(0, 0, 1, 2'd0, 32'h1002, 0, 0); cyc("R7 byte 1002 miss", 2'b00, 0);
    bus(0, 0, 1, 2'd1, 32'h1000, 0, 0); cyc("R7 word 1000 miss", 2'b00, 0);

    // R8 size condition word
    brk_size[0] = 2'b10;
    bus(0, 0, 1, 2'd2, 32'h1000, 0, 0); cyc("R8 long rejected", 2'b00, 0);
    bus(0, 0, 1, 2'd1, 32'h1002, 0, 0); cyc("R8 word accepted", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);

    // R9 qualifiers
    brk_size[0] = 2'b00; brk_dir[0] = 2'b10;
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); cyc("R9 read rejected", 2'b00, 0);
    bus(0, 1, 1, 2'd0, 32'h1003, 0, 0); cyc("R9 write accepted", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);
    brk_dir[0] = 2'b11; brk_master[0] = 2'b01;
    bus(0, 1, 0, 2'd0, 32'h1003, 0, 0); cyc("R9 other master rejected", 2'b00, 0);
    brk_master[0] = 2'b11; brk_kind[0] = 2'b01;
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); cyc("R9 data on fetch-only", 2'b00, 0);
    brk_kind[0] = 2'b10;

    // R11 dummy cycle
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 1); cyc("R11 dummy ignored", 2'b00, 0);

    // R12 set wins over clear
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); brk_clr = 2'b01;
    cyc("R12 set beats clear", 2'b01, 1);
    brk_clr = 2'b01;                    cyc("R12 clear", 2'b00, 0);

    // R13 enable
    brk_en[0] = 1'b0;
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); cyc("R13 disabled no set", 2'b00, 0);
    brk_en[0] = 1'b1;
    bus(0, 0, 1, 2'd0, 32'h1003, 0, 0); cyc("R13 enabled set", 2'b01, 1);
    brk_en[0] = 1'b0;                   cyc("R13 req masked", 2'b01, 0);
    brk_en[0] = 1'b1; brk_clr = 2'b01;  cyc("R12 clear", 2'b00, 0);

    // R10 data compare on channel 1
    brk_en[0] = 1'b0;
    setch(1, 32'h3000, 2'b11, 2'b10, 2'b11, 2'b00, 1'b0, 1'b1);
    brk_dval = 32'h0000_00A5; brk_dmask = 32'h0000_00FF;
    bus(0, 1, 1, 2'd2, 32'h3000, 32'h1234_56A5, 0); cyc("R10 data match", 2'b10, 1);
    brk_clr = 2'b10;                                 cyc("R12 clear", 2'b00, 0);
    bus(0, 1, 1, 2'd2, 32'h3000, 32'h1234_5600, 0); cyc("R10 data mismatch", 2'b00, 0);
    brk_kind[1] = 2'b01;
    fetch(32'h3000);      cyc("R10 fetch ignores data", 2'b00, 0);
    exe(32'h3000, 1'b1);  cyc("R10 fetch break on ch1", 2'b10, 1);
    brk_clr = 2'b10;      cyc("R12 clear", 2'b00, 0);

    @(negedge clk);
    done = 1;
    summary();
  end

endmodule